// File: doc/BRIEF.md
# Mesh Router Per-Hop Route Computation

This block is the route computation stage of a router in a K×K two-dimensional mesh. Each cycle it may accept one packet header and the router's own coordinates. It picks one of five output directions: East, West, North, South or Local. It also returns the header with its phase bit updated. The result appears one clock after the header is presented.

Headers run in one of two modes:

- **Single-leg mode.** The packet travels minimally to its destination in a chosen dimension order.
- **Two-leg mode.** The packet first travels minimally to an intermediate node in one dimension order. From there it travels to the destination in a second, independently chosen order. When the packet reaches the intermediate node, the block switches the target in the same cycle, so the hop leaving that node already heads for the destination.

Choosing the intermediate node is done elsewhere. Flow control and switching are also handled outside this block.

Header layout (LSB first, CW = coordinate width, with CW = 2 for K = 4):

| Field | Bits |
|-------|------|
| dst_x | [CW-1:0] |
| dst_y | [2CW-1:CW] |
| mid_x | [3CW-1:2CW] |
| mid_y | [4CW-1:3CW] |
| two_leg | bit 4CW |
| phase | bit 4CW+1 |
| ord_a (first-leg order) | bit 4CW+2 |
| ord_b (final-leg order) | bit 4CW+3 |

For both order bits, 0 means X first and 1 means Y first. X grows toward East and Y grows toward North.

Top module: `mesh_route_compute`

## Requirements
- R1: With the active order bit at 0 (X first), the block selects East or West while the current X differs from the target X. It selects North or South only once the X coordinates match.
- R2: With the active order bit at 1 (Y first), the block selects North or South while the current Y differs from the target Y. It selects East or West only once the Y coordinates match.
- R3: Every hop is minimal toward the active target:
  - East only if the target X is greater than the current X; West only if it is smaller.
  - North only if the target Y is greater than the current Y; South only if it is smaller.
- R4: In two-leg mode (two_leg=1) with phase=0, when the current node is not the intermediate node, the target is (mid_x, mid_y), the order is ord_a, and the output phase stays 0.
- R5: In two-leg mode with phase=0, when the current node equals the intermediate node, the output phase becomes 1. The route for that same hop is computed toward (dst_x, dst_y) using ord_b.
- R6: Local is selected exactly when the active target is the destination and the current node equals (dst_x, dst_y). This includes the case of two-leg mode where the current node equals both the intermediate node and the destination.
- R7: In single-leg mode (two_leg=0), the block ignores mid_x, mid_y, phase and ord_a. It routes toward (dst_x, dst_y) with ord_b, and the phase bit passes through unchanged.
- R8: A result is valid exactly one cycle after hdr_valid_i. out_port_o is then one-hot with bit order {Local, South, North, West, East} from bit 4 down to bit 0, and it is all zeros in cycles without a result.
- R9: While rst_ni is low, out_valid_o, out_port_o and hdr_o are all zero.
- R10: All header fields other than phase leave the block unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_valid_i | input | 1 | Header present this cycle |
| hdr_i | input | 4*CW+4 | Incoming header |
| cur_x_i | input | CW | Router X coordinate |
| cur_y_i | input | CW | Router Y coordinate |
| out_valid_o | output | 1 | Registered result valid |
| out_port_o | output | 5 | One-hot output direction |
| hdr_o | output | 4*CW+4 | Header with updated phase |

## Verification
Every result is due at the first rising edge after its header is driven. Back-to-back headers therefore produce back-to-back results with a fixed one-cycle lag.

The driver applies each header just after a rising edge and queues the expected direction and header. The monitor samples on the falling edge after the next rising edge. It pops one queued entry for every valid result and compares the two. A valid result with nothing queued counts as a mismatch, as does anything left in the queue at the end. Idle cycles are checked on the same falling edge for an absent strobe and an all-zero port.

// File: rtl/mesh_route_pkg.sv
package mesh_route_pkg;
  localparam int unsigned NUM_DIRS = 5;
  localparam int unsigned DIR_E = 0;
  localparam int unsigned DIR_W = 1;
  localparam int unsigned DIR_N = 2;
  localparam int unsigned DIR_S = 3;
  localparam int unsigned DIR_L = 4;

  typedef enum logic {
    ORD_X_FIRST = 1'b0,
    ORD_Y_FIRST = 1'b1
  } dim_order_e;
endpackage

// File: rtl/mesh_route_target.sv
// Resolves the active leg: target coordinates, order and outgoing phase.
module mesh_route_target #(
  parameter int unsigned CW = 2
) (
  input  logic [CW-1:0] cur_x_i,
  input  logic [CW-1:0] cur_y_i,
  input  logic [CW-1:0] dst_x_i,
  input  logic [CW-1:0] dst_y_i,
  input  logic [CW-1:0] mid_x_i,
  input  logic [CW-1:0] mid_y_i,
  input  logic          two_leg_i,
  input  logic          phase_i,
  input  logic          ord_a_i,
  input  logic          ord_b_i,
  output logic [CW-1:0] tgt_x_o,
  output logic [CW-1:0] tgt_y_o,
  output logic          ord_o,
  output logic          phase_o
);
  logic at_mid;
  logic final_leg;

  assign at_mid = (cur_x_i == mid_x_i) && (cur_y_i == mid_y_i);

  always_comb begin
    final_leg = !two_leg_i || phase_i || at_mid;
    tgt_x_o   = final_leg ? dst_x_i : mid_x_i;
    tgt_y_o   = final_leg ? dst_y_i : mid_y_i;
    ord_o     = final_leg ? ord_b_i : ord_a_i;
    phase_o   = two_leg_i ? final_leg : phase_i;
  end
endmodule

// File: rtl/mesh_route_dir.sv
// Dimension-ordered minimal direction toward a target.
module mesh_route_dir
  import mesh_route_pkg::*;
#(
  parameter int unsigned CW = 2
) (
  input  logic [CW-1:0]       cur_x_i,
  input  logic [CW-1:0]       cur_y_i,
  input  logic [CW-1:0]       tgt_x_i,
  input  logic [CW-1:0]       tgt_y_i,
  input  logic                ord_i,
  output logic [NUM_DIRS-1:0] dir_o
);
  logic x_ne, y_ne;
  logic [NUM_DIRS-1:0] x_step, y_step;

  assign x_ne = (cur_x_i != tgt_x_i);
  assign y_ne = (cur_y_i != tgt_y_i);

  always_comb begin
    x_step = '0;
    y_step = '0;
    x_step[(tgt_x_i > cur_x_i) ? DIR_E : DIR_W] = 1'b1;
    y_step[(tgt_y_i > cur_y_i) ? DIR_N : DIR_S] = 1'b1;
    dir_o = '0;
    if (!x_ne && !y_ne) begin
      dir_o[DIR_L] = 1'b1;
    end else if (dim_order_e'(ord_i) == ORD_X_FIRST) begin
      dir_o = x_ne ? x_step : y_step;
    end else begin
      dir_o = y_ne ? y_step : x_step;
    end
  end
endmodule

// File: rtl/mesh_route_compute.sv
module mesh_route_compute
  import mesh_route_pkg::*;
#(
  parameter int unsigned K     = 4,
  parameter int unsigned CW    = (K > 2) ? $clog2(K) : 1,
  parameter int unsigned HDR_W = 4 * CW + 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hdr_valid_i,
  input  logic [HDR_W-1:0]    hdr_i,
  input  logic [CW-1:0]       cur_x_i,
  input  logic [CW-1:0]       cur_y_i,
  output logic                out_valid_o,
  output logic [NUM_DIRS-1:0] out_port_o,
  output logic [HDR_W-1:0]    hdr_o
);
  localparam int unsigned B_TWO   = 4 * CW;
  localparam int unsigned B_PHASE = 4 * CW + 1;
  localparam int unsigned B_ORD_A = 4 * CW + 2;
  localparam int unsigned B_ORD_B = 4 * CW + 3;

  logic [CW-1:0]       tgt_x, tgt_y;
  logic                ord, phase_nx;
  logic [NUM_DIRS-1:0] dir;
  logic [HDR_W-1:0]    hdr_nx;

  mesh_route_target #(.CW(CW)) u_target (
    .cur_x_i  (cur_x_i),
    .cur_y_i  (cur_y_i),
    .dst_x_i  (hdr_i[CW-1:0]),
    .dst_y_i  (hdr_i[2*CW-1:CW]),
    .mid_x_i  (hdr_i[3*CW-1:2*CW]),
    .mid_y_i  (hdr_i[4*CW-1:3*CW]),
    .two_leg_i(hdr_i[B_TWO]),
    .phase_i  (hdr_i[B_PHASE]),
    .ord_a_i  (hdr_i[B_ORD_A]),
    .ord_b_i  (hdr_i[B_ORD_B]),
    .tgt_x_o  (tgt_x),
    .tgt_y_o  (tgt_y),
    .ord_o    (ord),
    .phase_o  (phase_nx)
  );

  mesh_route_dir #(.CW(CW)) u_dir (
    .cur_x_i(cur_x_i),
    .cur_y_i(cur_y_i),
    .tgt_x_i(tgt_x),
    .tgt_y_i(tgt_y),
    .ord_i  (ord),
    .dir_o  (dir)
  );

  always_comb begin
    hdr_nx          = hdr_i;
    hdr_nx[B_PHASE] = phase_nx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_port_o  <= '0;
      hdr_o       <= '0;
    end else begin
      out_valid_o <= hdr_valid_i;
      out_port_o  <= hdr_valid_i ? dir : '0;
      if (hdr_valid_i) hdr_o <= hdr_nx;
    end
  end

  // Checks, derived from the registered header against the sampled position
  logic          o_final;
  logic [CW-1:0] o_tx, o_ty;
  assign o_final = !hdr_o[B_TWO] || hdr_o[B_PHASE];
  assign o_tx    = o_final ? hdr_o[CW-1:0]    : hdr_o[3*CW-1:2*CW];
  assign o_ty    = o_final ? hdr_o[2*CW-1:CW] : hdr_o[4*CW-1:3*CW];

  AST_PORT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $countones(out_port_o) == 1) else $error("onehot"); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> out_port_o == '0) else $error("idle"); // R8
  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i |=> out_valid_o) else $error("latency"); // R8
  AST_EAST_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i && dir[DIR_E] |=> o_tx > $past(cur_x_i)) else $error("east"); // R3
  AST_WEST_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i && dir[DIR_W] |=> o_tx < $past(cur_x_i)) else $error("west"); // R3
  AST_NORTH_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i && dir[DIR_N] |=> o_ty > $past(cur_y_i)) else $error("north"); // R3
  AST_SOUTH_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i && dir[DIR_S] |=> o_ty < $past(cur_y_i)) else $error("south"); // R3
  AST_LOCAL_AT_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i && dir[DIR_L] |=> o_final && o_tx == $past(cur_x_i)
                                  && o_ty == $past(cur_y_i)) else $error("local"); // R6
  AST_PHASE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i && hdr_i[B_TWO] && hdr_i[B_PHASE] |=> hdr_o[B_PHASE]) else $error("phase"); // R5
  AST_FIELDS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i |=> hdr_o[4*CW-1:0] == $past(hdr_i[4*CW-1:0])) else $error("fields"); // R10
endmodule

// File: tb/mesh_route_compute_tb.sv
module mesh_route_compute_tb_top;
  localparam int unsigned K = 4;
  localparam int unsigned CW = 2;
  localparam int unsigned HW = 4 * CW + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic [HW-1:0] hdr = '0;
  logic [CW-1:0] cx = '0, cy = '0;
  logic ov;
  logic [4:0] op;
  logic [HW-1:0] oh;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [4:0]    port;
    logic [HW-1:0] hdr;
    string         tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  mesh_route_compute #(.K(K)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hdr_valid_i(vld), .hdr_i(hdr),
    .cur_x_i(cx), .cur_y_i(cy), .out_valid_o(ov), .out_port_o(op), .hdr_o(oh)
  );

  function automatic logic [HW-1:0] mk(int dx, int dy, int mx, int my,
                                       bit two, bit ph, bit oa, bit ob);
    return {ob, oa, ph, two, my[CW-1:0], mx[CW-1:0], dy[CW-1:0], dx[CW-1:0]};
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: apply a header and queue the expected result.
  task automatic drive(logic [HW-1:0] h, int x, int y,
                       logic [4:0] eport, logic [HW-1:0] ehdr, string tag);
    exp_t e;
    @(posedge clk);
    #1;
    vld = 1'b1;
    hdr = h;
    cx = x[CW-1:0];
    cy = y[CW-1:0];
    e.port = eport;
    e.hdr = ehdr;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      vld = 1'b0;
      hdr = '1;
    end
  endtask

  // Monitor: pop and compare each result.
  always @(negedge clk) begin
    if (rst_n && ov) begin
      if (q.size() == 0) begin
        check(1'b0, "R8", "unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(op == e.port, e.tag, "port", op, e.port);
        check(oh == e.hdr, e.tag, "header", oh, e.hdr);
      end
    end
  end

  localparam logic [4:0] PE = 5'b00001, PW = 5'b00010, PN = 5'b00100,
                         PS = 5'b01000, PL = 5'b10000;

  initial begin
    bit done;
    done = 1'b0;
    fork
      begin
        #20;
        @(negedge clk);
        check(!ov && op == 0 && oh == 0, "R9", "reset state", {ov, op}, 0);
        rst_n = 1'b1;
        idle(2);
        @(negedge clk);
        check(!ov && op == 0, "R8", "idle no result", {ov, op}, 0);

        // R1: X first, single leg
        drive(mk(3, 2, 0, 0, 0, 0, 0, 0), 1, 1, PE, mk(3, 2, 0, 0, 0, 0, 0, 0), "R1");
        // R2: Y first, same positions
        drive(mk(3, 2, 0, 0, 0, 0, 0, 1), 1, 1, PN, mk(3, 2, 0, 0, 0, 0, 0, 1), "R2");
        // R1/R3: X matches, go south
        drive(mk(2, 0, 0, 0, 0, 0, 0, 0), 2, 3, PS, mk(2, 0, 0, 0, 0, 0, 0, 0), "R1");
        // R2/R3: Y matches, go west
        drive(mk(0, 1, 0, 0, 0, 0, 0, 1), 3, 1, PW, mk(0, 1, 0, 0, 0, 0, 0, 1), "R2");
        // R3: far corner, west
        drive(mk(0, 0, 0, 0, 0, 0, 0, 0), 3, 3, PW, mk(0, 0, 0, 0, 0, 0, 0, 0), "R3");
        // R7/R6: single leg at dst; mid/phase/ord_a are junk and ignored
        drive(mk(2, 1, 0, 3, 0, 0, 1, 0), 2, 1, PL, mk(2, 1, 0, 3, 0, 0, 1, 0), "R7");
        // R7: mid equals cur but single leg -> still routes to dst with ord_b (Y first)
        drive(mk(3, 3, 1, 1, 0, 0, 0, 1), 1, 1, PN, mk(3, 3, 1, 1, 0, 0, 0, 1), "R7");
        // R4: heading to mid, X first
        drive(mk(3, 3, 2, 0, 1, 0, 0, 1), 0, 0, PE, mk(3, 3, 2, 0, 1, 0, 0, 1), "R4");
        // R4: heading to mid, Y first via ord_a
        drive(mk(0, 0, 1, 3, 1, 0, 1, 0), 1, 1, PN, mk(0, 0, 1, 3, 1, 0, 1, 0), "R4");
        // R5: at mid, flip phase, route to dst with ord_b=Y first
        drive(mk(3, 3, 2, 0, 1, 0, 0, 1), 2, 0, PN, mk(3, 3, 2, 0, 1, 1, 0, 1), "R5");
        // R5: at mid, ord_b=X first
        drive(mk(3, 3, 2, 0, 1, 0, 1, 0), 2, 0, PE, mk(3, 3, 2, 0, 1, 1, 1, 0), "R5");
        // R6: phase 1 at dst
        drive(mk(3, 3, 0, 0, 1, 1, 0, 0), 3, 3, PL, mk(3, 3, 0, 0, 1, 1, 0, 0), "R6");
        // R6: cur = mid = dst in phase 0
        drive(mk(1, 2, 1, 2, 1, 0, 0, 0), 1, 2, PL, mk(1, 2, 1, 2, 1, 1, 0, 0), "R6");
        // R10/R3: phase 1 ignores mid, Y first south
        drive(mk(3, 0, 0, 2, 1, 1, 0, 1), 0, 2, PS, mk(3, 0, 0, 2, 1, 1, 0, 1), "R10");
        idle(3);
        @(negedge clk);
        check(!ov && op == 0, "R8", "idle after burst", {ov, op}, 0);
        check(q.size() == 0, "R8", "results outstanding", q.size(), 0);
        done = 1'b1;
      end
      begin
        repeat (2000) @(posedge clk);
        if (!done) check(1'b0, "watchdog", "timeout", 0, 1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule